// File: doc/BRIEF.md
# Bidirectional Common Scan Register

This block moves a scan token along a row of common electrode outputs of a dot-matrix display panel. It holds one bit per output in a chain of stages. On each active edge of an external shift clock the chain moves one place, either from the left end toward the right or from the right end toward the left, with a new bit entering at the upstream end and the downstream end's bit leaving as serial output. The shift clock and the other inputs are sampled on a fast system clock, and the active edge of the shift clock (rising or falling) is chosen by a select input that is captured while reset is held.

Each stage does not drive its raw bit. It combines the bit with the AC inversion signal into a two-bit drive-level code naming one of four panel voltages. Two of the levels mean "selected" and two mean "not selected", and the inversion signal picks which one of each pair is used. The analog switches that turn a code into a voltage are outside this block. The two end pins are bidirectional at the pad: the block reports which end is driving through one enable per end, and that enable follows the direction select.

Top module: `com_scan_driver`

## Requirements
- R1: While reset is high, every stage is cleared to 0. After reset every output code shows a non-selected level, and both serial outputs are 0.
- R2: With `dir_fwd` = 1, an active shift edge loads `left_din` into stage 0 and moves each stage i into stage i+1.
- R3: With `dir_fwd` = 0, an active shift edge loads `right_din` into the last stage and moves each stage i into stage i-1.
- R4: `right_oe` equals `dir_fwd` and `left_oe` equals its inverse. The serial output of the end that is not driving is held at 0.
- R5: `right_dout` is the last stage when `dir_fwd` = 1. `left_dout` is stage 0 when `dir_fwd` = 0.
- R6: In rising mode the chain shifts only when `shift_clk` was sampled 0 and is now sampled 1. A falling transition leaves the chain unchanged.
- R7: In falling mode the chain shifts only when `shift_clk` was sampled 1 and is now sampled 0. A rising transition leaves the chain unchanged.
- R8: `edge_rise_sel` is captured only while reset is high (1 = rising mode, 0 = falling mode). Changing it after reset does not change which edge shifts.
- R9: The level code is 00 for data 1 with `ac_phase` 0, 01 for data 1 with `ac_phase` 1, 10 for data 0 with `ac_phase` 0, and 11 for data 0 with `ac_phase` 1. Bit 0 of each code always equals `ac_phase`. Bit 1 is the inverse of the stage data.
- R10: In cycles where `shift_clk` is sampled equal to its previous sample, no stage changes.
- R11: Stage i drives `level_codes[2*i+1:2*i]`. Stage 0 is the stage at the left end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all inputs |
| rst | input | 1 | Synchronous active-high reset; also captures the edge mode |
| shift_clk | input | 1 | External shift clock, sampled on `clk` |
| edge_rise_sel | input | 1 | 1 = shift on rising edge, 0 = shift on falling edge; captured during reset |
| dir_fwd | input | 1 | 1 = shift from the left end toward the right, 0 = shift from the right end toward the left |
| left_din | input | 1 | Serial data entering at the left end |
| right_din | input | 1 | Serial data entering at the right end |
| ac_phase | input | 1 | AC inversion signal |
| level_codes | output | 2*N_STAGES | One two-bit drive-level code per output; stage i at bits 2i+1:2i |
| left_dout | output | 1 | Serial data leaving the left end |
| right_dout | output | 1 | Serial data leaving the right end |
| left_oe | output | 1 | Left end pin drives |
| right_oe | output | 1 | Right end pin drives |

## Verification
The bench builds the block with its default of 64 stages. With that length a single token can be walked from one end to the other, which shows the end-to-end serial output, and then pushed back the other way. Random runs of a few thousand cycles switch the direction, the edge mode (through repeated resets), the inversion signal and the shift clock many times across the full chain, and each cycle is compared with a bench model of the whole register.

// File: rtl/com_scan_pkg.sv
`timescale 1ns/1ps
package com_scan_pkg;

    // Drive-level code carried by each stage output
    typedef enum logic [1:0] {
        LVL_SEL_LO  = 2'b00,   // selected, ac_phase low
        LVL_SEL_HI  = 2'b01,   // selected, ac_phase high
        LVL_IDLE_LO = 2'b10,   // non-selected, ac_phase low
        LVL_IDLE_HI = 2'b11    // non-selected, ac_phase high
    } drive_level_e;

    // One end of the serial chain as seen at the pad
    typedef struct packed {
        logic dout;
        logic oe;
    } end_pin_t;

    function automatic drive_level_e level_of(input logic data_bit, input logic phase);
        drive_level_e lvl;
        case ({data_bit, phase})
            2'b10:   lvl = LVL_SEL_LO;
            2'b11:   lvl = LVL_SEL_HI;
            2'b00:   lvl = LVL_IDLE_LO;
            default: lvl = LVL_IDLE_HI;
        endcase
        return lvl;
    endfunction

endpackage

// File: rtl/com_edge_detect.sv
`timescale 1ns/1ps
module com_edge_detect (
    input  logic clk,
    input  logic rst,
    input  logic shift_clk,
    input  logic edge_rise_sel,
    output logic shift_en
);
    logic prev_q;
    logic rise_mode_q;

    always_ff @(posedge clk) begin
        prev_q <= shift_clk;
        if (rst) begin
            rise_mode_q <= edge_rise_sel;
        end
    end

    always_comb begin
        if (rise_mode_q) begin
            shift_en = shift_clk & ~prev_q;
        end else begin
            shift_en = ~shift_clk & prev_q;
        end
    end
endmodule

// File: rtl/com_shift_chain.sv
`timescale 1ns/1ps
module com_shift_chain #(
    parameter int N_STAGES = 64
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                dir_fwd,
    input  logic                left_din,
    input  logic                right_din,
    output logic [N_STAGES-1:0] bits_q
);
    localparam int LAST = N_STAGES - 1;

    logic [N_STAGES-1:0] from_left;
    logic [N_STAGES-1:0] from_right;

    genvar i;
    generate
        for (i = 0; i < N_STAGES; i++) begin : g_stage
            if (i == 0) begin : g_head
                assign from_left[i] = left_din;
            end else begin : g_body
                assign from_left[i] = bits_q[i-1];
            end

            if (i == LAST) begin : g_tail
                assign from_right[i] = right_din;
            end else begin : g_inner
                assign from_right[i] = bits_q[i+1];
            end

            always_ff @(posedge clk) begin
                if (rst) begin
                    bits_q[i] <= 1'b0;
                end else if (shift_en) begin
                    bits_q[i] <= dir_fwd ? from_left[i] : from_right[i];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/com_level_map.sv
`timescale 1ns/1ps
module com_level_map
    import com_scan_pkg::*;
#(
    parameter int N_STAGES = 64
) (
    input  logic [N_STAGES-1:0]   bits_q,
    input  logic                  ac_phase,
    output logic [2*N_STAGES-1:0] level_codes
);
    genvar i;
    generate
        for (i = 0; i < N_STAGES; i++) begin : g_map
            drive_level_e lvl;
            assign lvl = level_of(bits_q[i], ac_phase);
            assign level_codes[2*i +: 2] = lvl;
        end
    endgenerate
endmodule

// File: rtl/com_scan_driver.sv
`timescale 1ns/1ps
module com_scan_driver
    import com_scan_pkg::*;
#(
    parameter int N_STAGES = 64
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift_clk,
    input  logic                  edge_rise_sel,
    input  logic                  dir_fwd,
    input  logic                  left_din,
    input  logic                  right_din,
    input  logic                  ac_phase,
    output logic [2*N_STAGES-1:0] level_codes,
    output logic                  left_dout,
    output logic                  right_dout,
    output logic                  left_oe,
    output logic                  right_oe
);
    logic                shift_en;
    logic [N_STAGES-1:0] bits_q;
    end_pin_t            left_end;
    end_pin_t            right_end;

    com_edge_detect u_edge (
        .clk           (clk),
        .rst           (rst),
        .shift_clk     (shift_clk),
        .edge_rise_sel (edge_rise_sel),
        .shift_en      (shift_en)
    );

    com_shift_chain #(.N_STAGES(N_STAGES)) u_chain (
        .clk       (clk),
        .rst       (rst),
        .shift_en  (shift_en),
        .dir_fwd   (dir_fwd),
        .left_din  (left_din),
        .right_din (right_din),
        .bits_q    (bits_q)
    );

    com_level_map #(.N_STAGES(N_STAGES)) u_map (
        .bits_q      (bits_q),
        .ac_phase    (ac_phase),
        .level_codes (level_codes)
    );

    always_comb begin
        left_end.oe    = ~dir_fwd;
        left_end.dout  = ~dir_fwd & bits_q[0];
        right_end.oe   = dir_fwd;
        right_end.dout = dir_fwd & bits_q[N_STAGES-1];
    end

    assign left_dout  = left_end.dout;
    assign left_oe    = left_end.oe;
    assign right_dout = right_end.dout;
    assign right_oe   = right_end.oe;
endmodule

// File: rtl/com_scan_checker.sv
`timescale 1ns/1ps
module com_scan_checker #(
    parameter int N_STAGES = 64
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  shift_clk,
    input logic                  edge_rise_sel,
    input logic                  dir_fwd,
    input logic                  left_din,
    input logic                  right_din,
    input logic                  ac_phase,
    input logic [2*N_STAGES-1:0] level_codes,
    input logic                  left_dout,
    input logic                  right_dout,
    input logic                  left_oe,
    input logic                  right_oe
);
    logic [N_STAGES-1:0] data_bits;
    logic [N_STAGES-1:0] phase_bits;
    logic [N_STAGES-1:0] fwd_next;
    logic [N_STAGES-1:0] bwd_next;
    logic                sc_prev;
    logic                rise_mode;
    logic                active_edge;

    genvar i;
    generate
        for (i = 0; i < N_STAGES; i++) begin : g_unpack
            assign data_bits[i]  = ~level_codes[2*i+1];
            assign phase_bits[i] = level_codes[2*i];
        end
    endgenerate

    assign fwd_next = {data_bits[N_STAGES-2:0], left_din};
    assign bwd_next = {right_din, data_bits[N_STAGES-1:1]};

    always_ff @(posedge clk) begin
        sc_prev <= shift_clk;
        if (rst) rise_mode <= edge_rise_sel;
    end

    assign active_edge = rise_mode ? (shift_clk & ~sc_prev) : (~shift_clk & sc_prev);

    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (data_bits == '0));

    assert_fwd_shift_R2: assert property (@(posedge clk) disable iff (rst)
        (active_edge && dir_fwd) |=> (data_bits == $past(fwd_next)));

    assert_bwd_shift_R3: assert property (@(posedge clk) disable iff (rst)
        (active_edge && !dir_fwd) |=> (data_bits == $past(bwd_next)));

    assert_end_enables_R4: assert property (@(posedge clk) disable iff (rst)
        $countones({left_oe, right_oe}) == 1 && right_oe == dir_fwd);

    assert_serial_out_R5: assert property (@(posedge clk) disable iff (rst)
        dir_fwd ? (right_dout == data_bits[N_STAGES-1] && !left_dout)
                : (left_dout == data_bits[0] && !right_dout));

    assert_phase_bit_R9: assert property (@(posedge clk) disable iff (rst)
        phase_bits == {N_STAGES{ac_phase}});

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (shift_clk == sc_prev) |=> $stable(data_bits));
endmodule

bind com_scan_driver com_scan_checker #(.N_STAGES(N_STAGES)) chk (.*);

// File: tb/com_scan_driver_test.sv
`timescale 1ns/1ps
module com_scan_driver_test;
    localparam int N = 64;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           shift_clk = 1'b0;
    logic           edge_rise_sel = 1'b1;
    logic           dir_fwd = 1'b1;
    logic           left_din = 1'b0;
    logic           right_din = 1'b0;
    logic           ac_phase = 1'b0;
    logic [2*N-1:0] level_codes;
    logic           left_dout, right_dout, left_oe, right_oe;

    int tests_run = 0;
    int tests_failed = 0;
    bit done = 1'b0;

    logic [N-1:0] mdl = '0;
    logic         mdl_prev = 1'b0;
    logic         mdl_rise = 1'b1;

    always #4 clk = ~clk;

    com_scan_driver #(.N_STAGES(N)) uut (
        .clk(clk), .rst(rst), .shift_clk(shift_clk), .edge_rise_sel(edge_rise_sel),
        .dir_fwd(dir_fwd), .left_din(left_din), .right_din(right_din), .ac_phase(ac_phase),
        .level_codes(level_codes), .left_dout(left_dout), .right_dout(right_dout),
        .left_oe(left_oe), .right_oe(right_oe)
    );

    // R9 / R11: expected code vector from model bits and phase
    function automatic logic [2*N-1:0] exp_codes(input logic [N-1:0] b, input logic m);
        logic [2*N-1:0] v;
        for (int i = 0; i < N; i++) v[2*i +: 2] = {~b[i], m};
        return v;
    endfunction

    task automatic check1(input string tag, input string what, input logic [2*N-1:0] act,
                          input logic [2*N-1:0] exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        check1(tag, "level_codes", level_codes, exp_codes(mdl, ac_phase));
        check1(tag, "right_dout", {{(2*N-1){1'b0}}, right_dout},
               {{(2*N-1){1'b0}}, dir_fwd & mdl[N-1]});
        check1(tag, "left_dout", {{(2*N-1){1'b0}}, left_dout},
               {{(2*N-1){1'b0}}, ~dir_fwd & mdl[0]});
        check1(tag, "oe", {{(2*N-2){1'b0}}, left_oe, right_oe},
               {{(2*N-2){1'b0}}, ~dir_fwd, dir_fwd});
    endtask

    task automatic model_edge();
        logic fire;
        if (rst) begin
            mdl = '0;
            mdl_rise = edge_rise_sel;
        end else begin
            fire = mdl_rise ? (shift_clk & ~mdl_prev) : (~shift_clk & mdl_prev);
            if (fire) mdl = dir_fwd ? {mdl[N-2:0], left_din} : {right_din, mdl[N-1:1]};
        end
        mdl_prev = shift_clk;
    endtask

    task automatic step(input logic sc, input logic d, input logic l, input logic r,
                        input logic m, input string tag);
        @(negedge clk);
        shift_clk = sc; dir_fwd = d; left_din = l; right_din = r; ac_phase = m;
        @(posedge clk);
        model_edge();
        #2;
        check_all(tag);
    endtask

    task automatic do_reset(input logic es, input logic sc);
        @(negedge clk);
        rst = 1'b1; edge_rise_sel = es; shift_clk = sc;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        model_edge();
        #2;
        check_all("R1");
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'h5A17);

        // R1: reset state, rising mode
        do_reset(1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R1");

        // R2 / R11 / R9: rising edge loads token into stage 0 (output 1, code 00)
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R2_R11");
        tests_run++;
        if (level_codes[1:0] !== 2'b00) begin
            tests_failed++;
            $display("FAIL R11 code1 actual=%b expected=00", level_codes[1:0]);
        end
        // R6: falling edge in rising mode does not shift
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R6");
        // R10: steady shift clock holds contents
        for (int k = 0; k < 3; k++) step(1'b0, 1'b1, 1'b1, 1'b0, k[0], "R10");

        // R8: change of edge select after reset has no effect
        edge_rise_sel = 1'b0;
        // R5: walk token to the right end
        for (int k = 0; k < N - 1; k++) begin
            step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R8_R2");
            step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R8_R6");
        end
        tests_run++;
        if (right_dout !== 1'b1) begin
            tests_failed++;
            $display("FAIL R5 right_dout actual=%b expected=1", right_dout);
        end

        // R3 / R4: reverse direction, token moves back toward the left
        step(1'b1, 1'b0, 1'b0, 1'b1, 1'b1, "R3_R4");
        step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3_R4");
        for (int k = 0; k < N; k++) begin
            step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R3_R5");
            step(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R3_R5");
        end

        // R7: falling mode
        do_reset(1'b0, 1'b1);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R7");
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b1, "R7");
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, "R7");
        edge_rise_sel = 1'b1;
        step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R8");
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R8");

        // Random mix, with occasional resets in either edge mode
        for (int k = 0; k < 3000; k++) begin
            logic [7:0] rv;
            rv = 8'($urandom);
            if (rv[7:3] == 5'd0) begin
                do_reset(rv[0], rv[1]);
            end else begin
                edge_rise_sel = rv[2];
                step(rv[0], rv[1] | rv[3], rv[4], rv[5], rv[6], "R2_R3_R9_R10");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end
endmodule